// File: doc/BRIEF.md
# Main Oscillator Stop Detector

This block watches the main oscillator (ceramic or RC) of a small controller and flags the moment it stops toggling. The free-running ring oscillator clocks the whole block. The main clock arrives only as a sampled data input. It passes through a synchronizer, and each change of level restarts a timeout counter. If the counter expires, the main clock is taken to have stopped. The block then sets a sticky status flag. If the stop-reset enable bit is set, it also raises a fixed-width internal reset request.

Software controls the block through a single write strobe that loads two bits: detection active and stop-reset enable. Both bits and the status flag can be read back on the block's outputs. The internal reset raised by the block does not clear either control bit, so detection stays armed after that reset. The status flag is cleared only by the external reset or by a write that sets detection active to 0. The external reset is asserted asynchronously and released synchronously. It returns the block to a disabled state.

Top module: `osc_stop_det`

## Requirements
- R1: While ext_rst_n is low and after its release, det_active, stop_rst_en, stop_flag and int_rst all read 0 until the first configuration write.
- R2: While detection is active and main_clk changes level at least once every TIMEOUT-1 ring cycles, stop_flag stays 0.
- R3: With detection active, stop_flag rises on the ring rising edge numbered TIMEOUT+3 after the last change of main_clk. The change is driven between edges, and the first rising edge after it counts as edge 1. On edge TIMEOUT+2 the flag is still 0.
- R4: When stop_rst_en is 0, a detected stop sets stop_flag and int_rst stays 0.
- R5: When stop_rst_en is 1, int_rst rises on the same edge as the stop_flag set. It stays high for exactly PULSE_W ring cycles (default 8).
- R6: Each stop event yields exactly one int_rst pulse. A further pulse needs a new main_clk change followed by a fresh timeout.
- R7: det_active and stop_rst_en change only on a configuration write (cfg_we high at a rising edge). The internal reset pulse leaves them unchanged.
- R8: Once set, stop_flag stays 1 when main_clk resumes, and also under a write with cfg_active=1.
- R9: A configuration write with cfg_active=0 clears stop_flag on that edge. This takes precedence over a stop detected in the same cycle.
- R10: While detection is inactive the timeout counter is held at zero, so a stopped main clock never sets the flag. After a write that activates detection with main_clk stopped, stop_flag rises on the rising edge numbered TIMEOUT+1 counted from the write edge, and not on edge TIMEOUT.
- R11: Asserting ext_rst_n low at any time clears stop_flag, int_rst, det_active and stop_rst_en, leaving detection disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ring | input | 1 | Ring oscillator clock, always running |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assert |
| main_clk | input | 1 | Main oscillator output, sampled as data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_active | input | 1 | Detection active value to write |
| cfg_rst_en | input | 1 | Stop-reset enable value to write |
| det_active | output | 1 | Current detection active bit |
| stop_rst_en | output | 1 | Current stop-reset enable bit |
| stop_flag | output | 1 | Sticky oscillation stop status |
| int_rst | output | 1 | Internal reset request pulse, active high |

## Verification
The checker enforces these rules on every cycle:
- a reset pulse appears only while the flag and the enable are set;
- the pulse never runs longer than PULSE_W cycles;
- the flag is sticky unless a clearing write occurs;
- the flag cannot become set while detection is off;
- the control bits move only on a write.

The bench scenarios supply the evidence that needs a particular stimulus history: the exact timeout latency in both the running and the freshly enabled case, exactly one pulse per stop, re-arming after the main clock resumes, and the external reset returning everything to the disabled state.

// File: rtl/osc_stop_pkg.sv
package osc_stop_pkg;

  typedef struct packed {
    logic active;
    logic rst_en;
  } osc_ctrl_t;

  localparam int unsigned DEF_TIMEOUT  = 16;
  localparam int unsigned DEF_PULSE_W  = 8;
  localparam int unsigned DEF_SYNC_LEN = 2;

endpackage

// File: rtl/osc_stop_rst_sync.sv
module osc_stop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/osc_stop_edge_sync.sv
module osc_stop_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign pipe_d[g] = async_in;
      end else begin : g_rest
        assign pipe_d[g] = pipe_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign edge_o = pipe_q[DEPTH-1] ^ pipe_q[DEPTH-2];

endmodule

// File: rtl/osc_stop_timeout.sv
module osc_stop_timeout #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic edge_i,
  output logic stop_evt_o
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] SAT  = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!active || edge_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != SAT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign stop_evt_o = active && !edge_i && (cnt_q == LAST);

endmodule

// File: rtl/osc_stop_pulse.sv
module osc_stop_pulse #(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);

  localparam int unsigned PW = $clog2(WIDTH + 1);
  localparam logic [PW-1:0] LOAD = PW'(WIDTH);

  logic [PW-1:0] left_q;
  logic [PW-1:0] left_d;
  logic          left_en;

  always_comb begin
    left_en = 1'b0;
    left_d  = left_q;
    if (fire) begin
      left_en = 1'b1;
      left_d  = LOAD;
    end else if (left_q != '0) begin
      left_en = 1'b1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/osc_stop_det.sv
module osc_stop_det
  import osc_stop_pkg::*;
#(
  parameter int unsigned TIMEOUT  = DEF_TIMEOUT,
  parameter int unsigned PULSE_W  = DEF_PULSE_W,
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
  input  logic clk_ring,
  input  logic ext_rst_n,
  input  logic main_clk,
  input  logic cfg_we,
  input  logic cfg_active,
  input  logic cfg_rst_en,
  output logic det_active,
  output logic stop_rst_en,
  output logic stop_flag,
  output logic int_rst
);

  logic      rst_n_sync;
  logic      main_edge;
  logic      stop_evt;
  logic      fire;
  osc_ctrl_t ctrl_q;
  osc_ctrl_t ctrl_d;
  logic      ctrl_en;
  logic      flag_q;
  logic      flag_d;
  logic      flag_en;

  osc_stop_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk     (clk_ring),
    .arst_n  (ext_rst_n),
    .rst_n_o (rst_n_sync)
  );

  osc_stop_edge_sync #(.STAGES(SYNC_LEN)) u_edge (
    .clk      (clk_ring),
    .rst_n    (rst_n_sync),
    .async_in (main_clk),
    .edge_o   (main_edge)
  );

  osc_stop_timeout #(.TIMEOUT(TIMEOUT)) u_timeout (
    .clk        (clk_ring),
    .rst_n      (rst_n_sync),
    .active     (ctrl_q.active),
    .edge_i     (main_edge),
    .stop_evt_o (stop_evt)
  );

  // Control bits: only a software write changes them (R7).
  always_comb begin
    ctrl_en = cfg_we;
    ctrl_d  = '{active: cfg_active, rst_en: cfg_rst_en};
  end

  always_ff @(posedge clk_ring or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Sticky status: a clearing write wins over a same-cycle stop (R9).
  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (cfg_we && !cfg_active) begin
      flag_en = 1'b1;
      flag_d  = 1'b0;
    end else if (stop_evt) begin
      flag_en = 1'b1;
      flag_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_ring or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign fire = stop_evt && ctrl_q.rst_en && !(cfg_we && !cfg_active);

  osc_stop_pulse #(.WIDTH(PULSE_W)) u_pulse (
    .clk     (clk_ring),
    .rst_n   (rst_n_sync),
    .fire    (fire),
    .pulse_o (int_rst)
  );

  assign det_active  = ctrl_q.active;
  assign stop_rst_en = ctrl_q.rst_en;
  assign stop_flag   = flag_q;

endmodule

// File: rtl/osc_stop_chk.sv
module osc_stop_chk #(
  parameter int unsigned PULSE_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic cfg_active,
  input logic det_active,
  input logic stop_rst_en,
  input logic stop_flag,
  input logic int_rst
);

  localparam int unsigned RW = $clog2(PULSE_W + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (int_rst) begin
      if (run_q != {RW{1'b1}}) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r5_pulse_max: assert (int'(run_q) <= int'(PULSE_W))
        else $error("pulse longer than PULSE_W");
    end
  end

  a_r4_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> stop_rst_en);

  a_r5_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> stop_flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && !(cfg_we && !cfg_active)) |=> stop_flag);

  a_r9_write0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_active) |=> !stop_flag);

  a_r10_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_active && !stop_flag) |=> !stop_flag);

  a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(det_active) && $stable(stop_rst_en)));

endmodule

bind osc_stop_det osc_stop_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk         (clk_ring),
  .rst_n       (rst_n_sync),
  .cfg_we      (cfg_we),
  .cfg_active  (cfg_active),
  .det_active  (det_active),
  .stop_rst_en (stop_rst_en),
  .stop_flag   (stop_flag),
  .int_rst     (int_rst)
);

// File: tb/osc_stop_det_tb.sv
`timescale 1ns/1ps
module osc_stop_det_tb;

  localparam int TIMEOUT = 16;
  localparam int PULSE_W = 8;

  logic clk_ring = 1'b0;
  logic ext_rst_n = 1'b0;
  logic main_clk = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_active = 1'b0;
  logic cfg_rst_en = 1'b0;
  logic det_active, stop_rst_en, stop_flag, int_rst;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  int pulses_seen = 0;
  int run_len = 0;
  bit done = 1'b0;

  always #10 clk_ring = ~clk_ring;

  osc_stop_det #(.TIMEOUT(TIMEOUT), .PULSE_W(PULSE_W)) u_dut (
    .clk_ring(clk_ring), .ext_rst_n(ext_rst_n), .main_clk(main_clk),
    .cfg_we(cfg_we), .cfg_active(cfg_active), .cfg_rst_en(cfg_rst_en),
    .det_active(det_active), .stop_rst_en(stop_rst_en),
    .stop_flag(stop_flag), .int_rst(int_rst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic a, input logic e);
    @(negedge clk_ring);
    cfg_we = 1'b1; cfg_active = a; cfg_rst_en = e;
    @(negedge clk_ring);
    cfg_we = 1'b0;
  endtask

  task automatic toggle_main(input int n, input int spacing);
    for (int i = 0; i < n; i++) begin
      repeat (spacing) @(negedge clk_ring);
      main_clk = ~main_clk;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk_ring);
    ext_rst_n = 1'b0;
    #3;
    check("R11 flag", stop_flag, 1'b0);
    check("R11 active", det_active, 1'b0);
    check("R11 rst_en", stop_rst_en, 1'b0);
    check("R11 int_rst", int_rst, 1'b0);
    repeat (3) @(negedge clk_ring);
    ext_rst_n = 1'b1;
    repeat (5) @(negedge clk_ring);
  endtask

  // Scoreboard monitor: each int_rst pulse is measured and matched.
  always @(negedge clk_ring) begin
    if (ext_rst_n) begin
      if (int_rst) begin
        run_len++;
      end else if (run_len > 0) begin
        pulses_seen++;
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R6 unexpected pulse: actual width %0d expected none", run_len);
        end else begin
          int w;
          w = exp_q.pop_front();
          if (w != run_len) begin
            n_fail++;
            $display("FAIL R5 pulse width: actual %0d expected %0d", run_len, w);
          end
        end
        run_len = 0;
      end
    end else begin
      run_len = 0;
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1 flag in reset", stop_flag, 1'b0);
    check("R1 int_rst in reset", int_rst, 1'b0);
    repeat (3) @(negedge clk_ring);
    ext_rst_n = 1'b1;
    repeat (5) @(negedge clk_ring);
    check("R1 active", det_active, 1'b0);
    check("R1 rst_en", stop_rst_en, 1'b0);
    check("R1 flag", stop_flag, 1'b0);
    check("R1 int_rst", int_rst, 1'b0);

    // R2: running main clock, detection active, flag only
    write_cfg(1'b1, 1'b0);
    check("R7 active after write", det_active, 1'b1);
    toggle_main(20, 5);
    check("R2 no stop while toggling", stop_flag, 1'b0);
    toggle_main(10, TIMEOUT - 1);
    check("R2 no stop at max spacing", stop_flag, 1'b0);

    // R3 / R4: stop latency, no pulse with enable 0
    repeat (TIMEOUT + 2) @(posedge clk_ring);
    #2 check("R3 flag not yet", stop_flag, 1'b0);
    @(posedge clk_ring);
    #2 check("R3 flag at TIMEOUT+3", stop_flag, 1'b1);
    repeat (30) @(negedge clk_ring);
    check("R4 no int_rst", int_rst, 1'b0);
    check("R4 no pulse seen", pulses_seen == 0, 1'b1);

    // R8: sticky through resume and a write with active=1
    toggle_main(8, 4);
    check("R8 sticky on resume", stop_flag, 1'b1);
    write_cfg(1'b1, 1'b0);
    check("R8 sticky on write 1", stop_flag, 1'b1);

    // R9: write 0 clears
    write_cfg(1'b0, 1'b0);
    check("R9 cleared by write 0", stop_flag, 1'b0);
    check("R9 active off", det_active, 1'b0);

    // R10: inactive holds counter; main stopped
    repeat (60) @(negedge clk_ring);
    check("R10 no flag while inactive", stop_flag, 1'b0);

    // R10 / R5: enable with reset-enable while main stopped
    exp_q.push_back(PULSE_W);
    write_cfg(1'b1, 1'b1);
    repeat (TIMEOUT - 1) @(posedge clk_ring);
    #2 check("R10 flag not at TIMEOUT", stop_flag, 1'b0);
    check("R5 int_rst not yet", int_rst, 1'b0);
    @(posedge clk_ring);
    #2 check("R10 flag at TIMEOUT+1", stop_flag, 1'b1);
    check("R5 int_rst with flag", int_rst, 1'b1);
    repeat (100) @(negedge clk_ring);
    check("R6 single pulse", pulses_seen == 1, 1'b1);
    check("R7 active kept", det_active, 1'b1);
    check("R7 rst_en kept", stop_rst_en, 1'b1);

    // R6: re-arm after main resumes
    toggle_main(6, 3);
    check("R6 no pulse while running", int_rst, 1'b0);
    exp_q.push_back(PULSE_W);
    repeat (60) @(negedge clk_ring);
    check("R6 second pulse after re-arm", pulses_seen == 2, 1'b1);
    check("R8 flag still set", stop_flag, 1'b1);

    // R11: external reset returns to disabled
    apply_reset();
    check("R11 active after", det_active, 1'b0);
    check("R11 flag after", stop_flag, 1'b0);
    repeat (60) @(negedge clk_ring);
    check("R11 disabled no flag", stop_flag, 1'b0);
    check("R11 disabled no pulse", pulses_seen == 2, 1'b1);
    check("R6 queue drained", exp_q.size() == 0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule